// File: doc/BRIEF.md
# I2C Serial EEPROM Slave Engine

This block is the bus-facing half of a 1 KB serial EEPROM. It oversamples the two-wire bus (SCL and SDA) with a fast system clock and finds START and STOP conditions. It then decodes the device-select byte and acknowledges the bytes it accepts. It also keeps a 10-bit address counter that spans four 256-byte blocks. The two block-select bits of the device-select byte form the top of the array address, and the word-address byte supplies the low eight bits.

On the write side, every accepted data byte becomes one request on a valid/ready port toward a separate program-cycle block. A one-cycle commit pulse at STOP tells that block to start programming. While that block reports busy, the engine stays off the bus. On the read side, the engine reads a synchronous memory port one byte at a time and shifts the bits out MSB first. It supports current-address reads, random reads (a dummy write followed by a repeated START) and sequential reads.

Write-port back-pressure rules: `wr_valid` rises when a data byte completes. It stays high, with address and data unchanged, until a cycle in which `wr_ready` is high. Only one request is ever outstanding. A data byte that completes while a request is still pending is not acknowledged and is dropped. The program-cycle block must accept any pending request before acting on `wr_commit`. It raises `prog_busy` only between transfers.

Top module: `eep_i2c_slave`

## Requirements
- R1: A START (SDA falls while SCL is high) restarts reception of the device-select byte from any state, including in the middle of a byte. A STOP (SDA rises while SCL is high) releases SDA and returns the engine to idle.
- R2: The device-select byte is received MSB first as type[3:0], A2, B1, B0, RW. It is accepted only when type is 4'b1010 and the A2 bit equals `strap_a2`. Otherwise the engine does not acknowledge it and leaves SDA released until the next START.
- R3: For every accepted received byte (device select, word address, data), the engine pulls SDA low for the whole 9th SCL clock and releases it after that clock's falling edge.
- R4: While `prog_busy` is high, the engine acknowledges no byte, so a device-select byte is answered with no ACK.
- R5: In a write (RW = 0), the word-address byte together with B1:B0 loads the 10-bit address {B1,B0,word}. Each data byte then issues one request with that address and the byte. A STOP after at least one such request pulses `wr_commit` for one cycle.
- R6: During a write the address advances only in its low 4 bits, so a page write wraps from offset 15 back to offset 0 of the same 16-byte page.
- R7: A request is held stable until accepted. A data byte that completes while a request is pending gets no ACK, issues no request and does not advance the address.
- R8: In a read (RW = 1), the engine drives 8 bits MSB first, then releases SDA for the master's acknowledge. A low acknowledge causes the next byte to be sent. A high one causes the engine to release SDA and ignore SCL until the next START or STOP.
- R9: A current-address read returns the byte one past the last byte read or written.
- R10: During a sequential read all 10 address bits advance, wrapping from 0x3FF to 0x000.
- R11: A write-mode select byte with a word address, then a repeated START and a read-mode select byte, returns the byte at the loaded address.
- R12: The engine changes its SDA drive only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line as seen on the wire |
| sda_pull | output | 1 | 1 pulls SDA low (open-drain enable) |
| strap_a2 | input | 1 | Device-address strap compared with select bit 3 |
| rd_en | output | 1 | Memory read strobe, one cycle |
| rd_addr | output | 10 | Memory read address |
| rd_data | input | 8 | Read data, valid the cycle after `rd_en` |
| wr_valid | output | 1 | Write request pending |
| wr_ready | input | 1 | Program block accepts the request |
| wr_addr | output | 10 | Write request address |
| wr_data | output | 8 | Write request data |
| wr_commit | output | 1 | One-cycle pulse at STOP ending a write with data |
| prog_busy | input | 1 | Program cycle in progress |

## Verification
Three behaviours are checked on every cycle: that the SDA drive moves only while SCL is low, that a pending write request holds its address and data, and that no acknowledge starts during a busy program cycle. STOP releasing the bus within a fixed number of cycles is also checked continuously. Address formation, page wrap, the array-wide read wrap, current-address continuity after both reads and writes, the mid-byte restart and the dropping of a byte under back-pressure all depend on the content and order of whole transfers. Only the directed scenarios can show those.

// File: rtl/eep_pkg.sv
`timescale 1ns/1ps
package eep_pkg;
  localparam int BLK_W  = 2;
  localparam int ADDR_W = 8 + BLK_W;
  localparam logic [3:0] DEV_TYPE = 4'b1010;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_WORD,
    ST_WRITE,
    ST_READ
  } eep_state_e;
endpackage

// File: rtl/eep_bus_sync.sv
`timescale 1ns/1ps
module eep_bus_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_sh, sda_sh;
  logic scl_q, sda_q, scl_s;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[STAGES-2:0], scl_i};
      sda_sh <= {sda_sh[STAGES-2:0], sda_i};
      scl_q  <= scl_s;
      sda_q  <= sda_s;
    end
  end

  assign scl_s     = scl_sh[STAGES-1];
  assign sda_s     = sda_sh[STAGES-1];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/eep_addr_ctr.sv
`timescale 1ns/1ps
module eep_addr_ctr #(
  parameter int AW        = 10,
  parameter int PAGE_BITS = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] load_val,
  input  logic          inc_full,
  input  logic          inc_page,
  output logic [AW-1:0] cnt
);
  logic [PAGE_BITS-1:0] page_off;
  assign page_off = cnt[PAGE_BITS-1:0] + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n)        cnt <= '0;
    else if (load)     cnt <= load_val;
    else if (inc_full) cnt <= cnt + 1'b1;
    else if (inc_page) cnt <= {cnt[AW-1:PAGE_BITS], page_off};
  end
endmodule

// File: rtl/eep_i2c_slave.sv
`timescale 1ns/1ps
module eep_i2c_slave
  import eep_pkg::*;
#(
  parameter int PAGE_BITS   = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_pull,
  input  logic              strap_a2,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [7:0]        rd_data,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data,
  output logic              wr_commit,
  input  logic              prog_busy
);
  logic sda_s, scl_rise, scl_fall, start_det, stop_det;

  eep_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  eep_state_e         state, nxt;
  logic [3:0]         bitcnt;
  logic [7:0]         shreg;
  logic               in_ack, mack, wrote, ld_q;
  logic [BLK_W-1:0]   blk;
  logic [ADDR_W-1:0]  cnt;

  logic rx_state, byte_done, ack_end, sel_ok, req_free, take_data, fetch, ctr_load;

  always_comb begin
    rx_state  = (state == ST_DEV) || (state == ST_WORD) || (state == ST_WRITE);
    byte_done = rx_state && scl_fall && (bitcnt == 4'd8) && !in_ack;
    ack_end   = rx_state && scl_fall && in_ack;
    sel_ok    = (shreg[7:4] == DEV_TYPE) && (shreg[3] == strap_a2) && !prog_busy;
    req_free  = !wr_valid || wr_ready;
    take_data = byte_done && (state == ST_WRITE) && req_free && !prog_busy;
    ctr_load  = byte_done && (state == ST_WORD) && !prog_busy;
    fetch     = (ack_end && (nxt == ST_READ)) ||
                ((state == ST_READ) && scl_fall && (bitcnt == 4'd8) && mack);
  end

  eep_addr_ctr #(.AW(ADDR_W), .PAGE_BITS(PAGE_BITS)) u_ctr (
    .clk(clk), .rst_n(rst_n), .load(ctr_load), .load_val({blk, shreg}),
    .inc_full(fetch), .inc_page(take_data), .cnt(cnt)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      nxt       <= ST_IDLE;
      bitcnt    <= '0;
      shreg     <= '0;
      in_ack    <= 1'b0;
      mack      <= 1'b0;
      wrote     <= 1'b0;
      ld_q      <= 1'b0;
      blk       <= '0;
      sda_pull  <= 1'b0;
      rd_en     <= 1'b0;
      rd_addr   <= '0;
      wr_valid  <= 1'b0;
      wr_addr   <= '0;
      wr_data   <= '0;
      wr_commit <= 1'b0;
    end else begin
      rd_en     <= fetch;
      ld_q      <= rd_en;
      wr_commit <= 1'b0;
      if (fetch) rd_addr <= cnt;
      if (wr_valid && wr_ready) wr_valid <= 1'b0;
      if (take_data) begin
        wr_valid <= 1'b1;
        wr_addr  <= cnt;
        wr_data  <= shreg;
        wrote    <= 1'b1;
      end

      if (stop_det) begin
        state     <= ST_IDLE;
        sda_pull  <= 1'b0;
        in_ack    <= 1'b0;
        wr_commit <= wrote;
        wrote     <= 1'b0;
      end else if (start_det) begin
        state    <= ST_DEV;
        bitcnt   <= '0;
        in_ack   <= 1'b0;
        sda_pull <= 1'b0;
      end else begin
        case (state)
          ST_DEV, ST_WORD, ST_WRITE: begin
            if (scl_rise && bitcnt < 4'd8) begin
              shreg  <= {shreg[6:0], sda_s};
              bitcnt <= bitcnt + 1'b1;
            end
            if (byte_done) begin
              case (state)
                ST_DEV: begin
                  if (sel_ok) begin
                    sda_pull <= 1'b1;
                    in_ack   <= 1'b1;
                    blk      <= shreg[2:1];
                    nxt      <= shreg[0] ? ST_READ : ST_WORD;
                  end else begin
                    state <= ST_IDLE;
                  end
                end
                ST_WORD: begin
                  if (prog_busy) state <= ST_IDLE;
                  else begin
                    sda_pull <= 1'b1;
                    in_ack   <= 1'b1;
                    nxt      <= ST_WRITE;
                  end
                end
                default: begin
                  sda_pull <= take_data;
                  in_ack   <= 1'b1;
                  nxt      <= ST_WRITE;
                end
              endcase
            end
            if (ack_end) begin
              sda_pull <= 1'b0;
              in_ack   <= 1'b0;
              bitcnt   <= '0;
              state    <= nxt;
            end
          end
          ST_READ: begin
            if (ld_q) begin
              shreg    <= rd_data;
              sda_pull <= ~rd_data[7];
            end else if (scl_fall && bitcnt < 4'd7) begin
              shreg    <= {shreg[6:0], 1'b0};
              sda_pull <= ~shreg[6];
              bitcnt   <= bitcnt + 1'b1;
            end else if (scl_fall && bitcnt == 4'd7) begin
              sda_pull <= 1'b0;
              bitcnt   <= 4'd8;
            end else if (scl_fall && bitcnt == 4'd8) begin
              if (mack) bitcnt <= '0;
              else      state  <= ST_IDLE;
            end
            if (scl_rise && bitcnt == 4'd8) mack <= ~sda_s;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/eep_i2c_chk.sv
`timescale 1ns/1ps
module eep_i2c_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_i,
  input logic       sda_i,
  input logic       sda_pull,
  input logic       wr_valid,
  input logic       wr_ready,
  input logic [9:0] wr_addr,
  input logic [7:0] wr_data,
  input logic       prog_busy
);
  p_drive_scl_low_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_pull) |-> !scl_i);

  p_req_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr) && $stable(wr_data));

  p_busy_no_ack_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull) |-> !$past(prog_busy));

  p_stop_release_r1: assert property (@(posedge clk) disable iff (!rst_n)
    scl_i && $past(scl_i) && sda_i && !$past(sda_i) |-> ##3 !sda_pull);
endmodule

bind eep_i2c_slave eep_i2c_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i), .sda_pull(sda_pull),
  .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
  .prog_busy(prog_busy)
);

// File: tb/sim_eep_i2c_slave.sv
`timescale 1ns/1ps
module sim_eep_i2c_slave;
  localparam int Q = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1, sda_m = 1'b1;
  logic sda_pull, rd_en, wr_valid, wr_commit;
  logic [9:0] rd_addr, wr_addr;
  logic [7:0] rd_data, wr_data;
  logic bp_ready = 1'b1;
  logic sda_bus;
  int checks = 0, errors = 0;
  int req_cnt = 0, commit_cnt = 0, busy_cnt = 0;
  logic [9:0] req_addr [0:31];
  logic [7:0] req_data [0:31];
  logic [7:0] mem [0:1023];
  bit done = 0;

  always #10 clk = ~clk;
  assign sda_bus = sda_m & ~sda_pull;

  eep_i2c_slave u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus), .sda_pull(sda_pull),
    .strap_a2(1'b1), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .wr_valid(wr_valid), .wr_ready(bp_ready), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_commit(wr_commit), .prog_busy(busy_cnt != 0)
  );

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 37 + 11) & 255);
  endfunction

  initial for (int i = 0; i < 1024; i++) mem[i] = pat(i);

  always @(posedge clk) begin
    if (rd_en) rd_data <= mem[rd_addr];
    if (wr_valid && bp_ready) begin
      mem[wr_addr] <= wr_data;
      req_addr[req_cnt % 32] <= wr_addr;
      req_data[req_cnt % 32] <= wr_data;
      req_cnt <= req_cnt + 1;
    end
    if (wr_commit) begin
      commit_cnt <= commit_cnt + 1;
      busy_cnt <= 300;
    end else if (busy_cnt != 0) busy_cnt <= busy_cnt - 1;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bstart();
    sda_m = 1'b1; wq(Q); scl = 1'b1; wq(Q); sda_m = 1'b0; wq(Q); scl = 1'b0; wq(Q);
  endtask

  task automatic bstop();
    sda_m = 1'b0; wq(Q); scl = 1'b1; wq(Q); sda_m = 1'b1; wq(2*Q);
  endtask

  task automatic send_bit(input logic b);
    sda_m = b; wq(Q); scl = 1'b1; wq(2*Q); scl = 1'b0; wq(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    sda_m = 1'b1; wq(Q); scl = 1'b1; wq(Q); ack = ~sda_bus; wq(Q); scl = 1'b0; wq(Q);
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      sda_m = 1'b1; wq(Q); scl = 1'b1; wq(Q); b[i] = sda_bus; wq(Q); scl = 1'b0; wq(Q);
    end
    send_bit(~give_ack);
    sda_m = 1'b1;
  endtask

  task automatic wait_idle();
    wq(4);
    while (busy_cnt != 0) wq(1);
    wq(4);
  endtask

  task automatic t_reset();
    wq(2);
    chk("R1 reset sda_pull", int'(sda_pull), 0);
    chk("R5 reset wr_valid", int'(wr_valid), 0);
    chk("R8 reset rd_en", int'(rd_en), 0);
  endtask

  task automatic t_bad_select();
    logic a;
    bstart(); send_byte(8'hA0, a); bstop();
    chk("R2 A2 mismatch no ACK", int'(a), 0);
    bstart(); send_byte(8'hB8, a);
    chk("R2 wrong type no ACK", int'(a), 0);
    send_byte(8'h00, a);
    chk("R2 released after reject", int'(a), 0);
    bstop();
  endtask

  task automatic t_byte_write();
    logic a0, a1, a2;
    int r0 = req_cnt, c0 = commit_cnt;
    bstart(); send_byte(8'hAC, a0); send_byte(8'h35, a1); send_byte(8'h5A, a2);
    chk("R3 select ACK", int'(a0), 1);
    chk("R3 word ACK", int'(a1), 1);
    chk("R3 data ACK", int'(a2), 1);
    chk("R5 one request", req_cnt - r0, 1);
    chk("R5 request addr", int'(req_addr[r0 % 32]), 'h235);
    chk("R5 request data", int'(req_data[r0 % 32]), 'h5A);
    bstop(); wq(2);
    chk("R5 commit at STOP", commit_cnt - c0, 1);
  endtask

  task automatic t_busy();
    logic a;
    bstart(); send_byte(8'hA8, a); bstop();
    chk("R4 no ACK while busy", int'(a), 0);
    wait_idle();
  endtask

  task automatic cur_read(input string req, input int exp_addr);
    logic a; logic [7:0] d;
    bstart(); send_byte(8'hA9, a); recv_byte(1'b0, d); bstop();
    chk("R2 read select ACK", int'(a), 1);
    chk(req, int'(d), int'(mem[exp_addr]));
  endtask

  task automatic t_page_write();
    logic a; int r0 = req_cnt;
    bstart(); send_byte(8'hAE, a); send_byte(8'h0E, a);
    send_byte(8'hC1, a); send_byte(8'hC2, a); send_byte(8'hC3, a); bstop();
    wait_idle();
    chk("R6 page addr 0", int'(req_addr[r0 % 32]), 'h30E);
    chk("R6 page addr 1", int'(req_addr[(r0+1) % 32]), 'h30F);
    chk("R6 page wrap addr", int'(req_addr[(r0+2) % 32]), 'h300);
    chk("R6 wrapped data", int'(req_data[(r0+2) % 32]), 'hC3);
  endtask

  task automatic t_random_seq();
    logic a; logic [7:0] d;
    bstart(); send_byte(8'hAE, a); send_byte(8'hFE, a);
    bstart(); send_byte(8'hA9, a);
    chk("R11 repeated START select ACK", int'(a), 1);
    recv_byte(1'b1, d); chk("R11 random read 0x3FE", int'(d), int'(mem['h3FE]));
    recv_byte(1'b1, d); chk("R10 seq 0x3FF", int'(d), int'(mem['h3FF]));
    recv_byte(1'b1, d); chk("R10 wrap to 0x000", int'(d), int'(mem['h000]));
    recv_byte(1'b0, d); chk("R8 last byte 0x001", int'(d), int'(mem['h001]));
    recv_byte(1'b0, d); chk("R8 released after NACK", int'(d), 'hFF);
    bstop();
  endtask

  task automatic t_mid_restart();
    logic a; logic [7:0] d;
    bstart(); send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b0);
    bstart(); send_byte(8'hA9, a);
    chk("R1 restart select ACK", int'(a), 1);
    recv_byte(1'b0, d); bstop();
    chk("R1 R9 read after restart", int'(d), int'(mem['h003]));
  endtask

  task automatic t_backpressure();
    logic a0, a1, a2; int r0 = req_cnt;
    bp_ready = 1'b0;
    bstart(); send_byte(8'hA8, a0); send_byte(8'h10, a0); send_byte(8'h11, a1);
    send_byte(8'h22, a2);
    chk("R7 first byte ACK", int'(a1), 1);
    chk("R7 second byte no ACK", int'(a2), 0);
    chk("R7 request held valid", int'(wr_valid), 1);
    chk("R7 held addr", int'(wr_addr), 'h010);
    chk("R7 held data", int'(wr_data), 'h11);
    bp_ready = 1'b1; wq(2);
    bstop(); wait_idle();
    chk("R7 one request accepted", req_cnt - r0, 1);
    chk("R7 dropped byte not written", int'(mem['h011]), int'(pat('h011)));
  endtask

  initial begin
    wq(5); rst_n = 1'b1; wq(5);
    t_reset();
    t_bad_select();
    t_byte_write();
    t_busy();
    cur_read("R9 after write", 'h236);
    cur_read("R9 after read", 'h237);
    t_page_write();
    t_random_seq();
    cur_read("R9 after sequential", 'h002);
    t_mid_restart();
    t_backpressure();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule